// File: doc/BRIEF.md
# Cyclic-Shift Chip Spreader

This block turns a stream of 4-bit data symbols into serial chips for a direct-sequence transmitter. It stores no table of sixteen codes. Every code word comes from one fixed root word: the low three bits of the symbol choose a cyclic rotation to the right, and the top bit chooses whether the odd-indexed chips of the root are inverted before that rotation. Each symbol goes out as a frame of N+1 chips. A cyclic prefix chip, which is a copy of the code word's last chip, comes first and guards against inter-symbol interference. The N chips of the code word follow it.

A symbol source offers symbols on a valid/ready handshake. The modulator takes one chip for each pulse of `chip_en`. The frame's first chip, the prefix, carries a start-of-symbol flag. Chips are single bits: 0 stands for the antipodal level +1 and 1 stands for −1. The parameter `CHIPS` selects an 8-chip root (0x5C) or a 16-chip root (0x2F53).

Top module: `cyclic_spreader`

## Requirements
- R1: While reset is held and on the first cycle after it, `sym_ready` is 1, and `chip_valid` and `chip_sos` are 0.
- R2: A symbol is taken on a clock edge where `sym_valid` and `sym_ready` are both 1. In the next cycle `chip_valid` and `chip_sos` are 1 and `sym_ready` is 0. `chip_sos` is 1 only on the first chip of a frame.
- R3: A frame holds exactly CHIPS+1 chips. The first is a copy of the code word's last chip, and code-word chips 0 to CHIPS−1 follow it in index order.
- R4: Chip index 0 of the root is the root's most significant bit. For CHIPS=8 and symbol value 0, the code word in transmit order is 0,1,0,1,1,1,0,0 (root 0x5C).
- R5: For symbol values 1 to 7 (bit 3 clear), the code word is the root rotated right by the value: chip i equals root chip (i − value) mod CHIPS. For CHIPS=8, value 1 gives 00101110 and value 2 gives 00010111.
- R6: When symbol bit 3 is 1, root chips with odd index (1, 3, 5, …) are inverted first, and the result is rotated right by bits 2:0. For CHIPS=8, value 8 gives 00001001 and value 9 gives 10000100.
- R7: A chip advances only on a clock edge where `chip_en` is 1. While `chip_en` is 0, `chip_out`, `chip_sos` and `chip_valid` hold.
- R8: `sym_ready` stays 0 for the whole frame. A `sym_valid` pulse during a frame is ignored and changes neither the chips of that frame nor the symbol sent next.
- R9: `sym_ready` returns to 1 in the cycle after the edge that takes the last chip, so symbols can be sent back to back with a single handshake cycle between frames.
- R10: With CHIPS=16, the root is 0x2F53 and the same rotation, inversion and prefix rules apply, giving 17-chip frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | A symbol is offered |
| sym_data | input | 4 | Symbol value; bit 3 selects inversion, bits 2:0 select the rotation |
| sym_ready | output | 1 | The block can take a symbol |
| chip_en | input | 1 | The modulator takes the current chip on this edge |
| chip_out | output | 1 | Current chip, 0 = +1 and 1 = −1 |
| chip_valid | output | 1 | A chip of a frame is being presented |
| chip_sos | output | 1 | The current chip is the frame's prefix chip |

## Verification
The first chip of a frame is on the outputs in the cycle after the accepting edge. Each later chip appears one cycle after a `chip_en` edge. `sym_ready` rises one cycle after the edge that takes chip CHIPS. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read exactly one register stage after the edge that caused it. During stalls the bench re-samples the same chip a cycle later to confirm that it holds.

// File: rtl/cspread_pkg.sv
// Package: shared types and root-word selection for the cyclic spreader.
// Assumes a chip count of 8 or 16; any other value falls back to the 8-chip root.
package cspread_pkg;

    typedef logic [3:0] sym_t;

    // Returns the root code word for the given chip count, MSB = chip index 0.
    function automatic logic [15:0] root_for(input int n);
        return (n == 16) ? 16'h2F53 : 16'h005C;
    endfunction

endpackage

// File: rtl/cspread_ctrl.sv
// Frame sequencer: holds the accepted symbol and counts frame positions
// 0..N (0 = prefix chip). Assumes chip_en is only meaningful while busy.
module cspread_ctrl
    import cspread_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_valid,
    input  sym_t          sym_in,
    input  logic          chip_en,
    output logic          busy,
    output logic [PW-1:0] pos,
    output sym_t          sym_q
);

    localparam logic [PW-1:0] LAST = PW'(N);

    // Accept a symbol when idle; step the position on each chip enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            pos   <= '0;
            sym_q <= '0;
        end else if (!busy) begin
            if (sym_valid) begin
                busy  <= 1'b1;
                pos   <= '0;
                sym_q <= sym_in;
            end
        end else if (chip_en) begin
            if (pos == LAST) begin
                busy <= 1'b0;
                pos  <= '0;
            end else begin
                pos <= pos + PW'(1);
            end
        end
    end

endmodule

// File: rtl/cspread_chip.sv
// Chip generator: maps a frame position and a symbol to one chip, using
// rotation and odd-chip inversion of a single root. Assumes N is a power of two.
module cspread_chip
    import cspread_pkg::*;
#(
    parameter int          N    = 8,
    parameter logic [N-1:0] ROOT = N'(8'h5C),
    parameter int          PW   = $clog2(N + 1)
) (
    input  logic [PW-1:0] pos,
    input  sym_t          sym,
    output logic          chip
);

    localparam int IW = $clog2(N);

    logic [PW-1:0] pos_m1;
    logic [IW-1:0] idx;
    logic [IW-1:0] base_idx;
    logic [IW-1:0] bit_sel;

    // Frame position 0 carries the word's last chip; others carry index pos-1.
    always_comb begin
        pos_m1 = pos - PW'(1);
        idx    = (pos == '0) ? IW'(N - 1) : pos_m1[IW-1:0];
    end

    // Undo the right rotation, then pick the root bit (MSB first) and invert odd chips.
    always_comb begin
        base_idx = idx - IW'(sym[2:0]);
        bit_sel  = IW'(N - 1) - base_idx;
        chip     = ROOT[bit_sel] ^ (sym[3] & base_idx[0]);
    end

endmodule

// File: rtl/cyclic_spreader.sv
// Top: cyclic-shift chip spreader. Takes 4-bit symbols on valid/ready and emits
// CHIPS+1 chips per symbol (cyclic prefix first) on chip_en pulses.
// Assumes CHIPS is 8 or 16.
module cyclic_spreader
    import cspread_pkg::*;
#(
    parameter int CHIPS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [3:0] sym_data,
    output logic       sym_ready,
    input  logic       chip_en,
    output logic       chip_out,
    output logic       chip_valid,
    output logic       chip_sos
);

    localparam int              PW       = $clog2(CHIPS + 1);
    localparam logic [15:0]     ROOT_ALL = root_for(CHIPS);
    localparam logic [CHIPS-1:0] ROOT    = ROOT_ALL[CHIPS-1:0];

    logic          busy;
    logic [PW-1:0] pos;
    sym_t          sym_q;
    logic          chip_raw;

    cspread_ctrl #(.N(CHIPS), .PW(PW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_in    (sym_data),
        .chip_en   (chip_en),
        .busy      (busy),
        .pos       (pos),
        .sym_q     (sym_q)
    );

    cspread_chip #(.N(CHIPS), .ROOT(ROOT), .PW(PW)) u_chip (
        .pos  (pos),
        .sym  (sym_q),
        .chip (chip_raw)
    );

    // Drive the handshake and chip outputs; chips read 0 while idle.
    always_comb begin
        sym_ready  = !busy;
        chip_valid = busy;
        chip_out   = busy & chip_raw;
        chip_sos   = busy && (pos == '0);
    end

endmodule

// File: rtl/cyclic_spreader_chk.sv
// Checker: protocol and framing properties of cyclic_spreader, bound to every instance.
// Keeps its own chip counter and captured prefix chip.
module cyclic_spreader_chk #(
    parameter int CHIPS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid,
    input logic       sym_ready,
    input logic       chip_en,
    input logic       chip_out,
    input logic       chip_valid,
    input logic       chip_sos
);

    localparam int PW = $clog2(CHIPS + 1);

    logic [PW-1:0] cnt;
    logic          ext_q;

    // Count chips taken since the last accepted symbol; remember the prefix chip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ext_q <= 1'b0;
        end else begin
            if (sym_valid && sym_ready)       cnt <= '0;
            else if (chip_valid && chip_en)   cnt <= cnt + PW'(1);
            if (chip_sos && chip_en)          ext_q <= chip_out;
        end
    end

    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready) |=> (chip_valid && chip_sos && !sym_ready));

    assert_sos_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sos |-> (chip_valid && cnt == '0));

    assert_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && chip_en && cnt == PW'(CHIPS)) |=> (sym_ready && !chip_valid));

    assert_frame_continues_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && chip_en && cnt < PW'(CHIPS)) |=> chip_valid);

    assert_prefix_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && cnt == PW'(CHIPS)) |-> (chip_out == ext_q));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !chip_en) |=> (chip_valid && $stable(chip_out) && $stable(chip_sos)));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |-> !sym_ready);

endmodule

bind cyclic_spreader cyclic_spreader_chk #(.CHIPS(CHIPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid  (sym_valid),
    .sym_ready  (sym_ready),
    .chip_en    (chip_en),
    .chip_out   (chip_out),
    .chip_valid (chip_valid),
    .chip_sos   (chip_sos)
);

// File: tb/cyclic_spreader_test.sv
`timescale 1ns/1ps
module cyclic_spreader_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic       n_valid = 1'b0, n_en = 1'b0;
    logic [3:0] n_data = 4'd0;
    logic       n_ready, n_chip, n_cvalid, n_sos;

    logic       w_valid = 1'b0, w_en = 1'b0;
    logic [3:0] w_data = 4'd0;
    logic       w_ready, w_chip, w_cvalid, w_sos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cyclic_spreader #(.CHIPS(8)) uut (
        .clk(clk), .rst_n(rst_n), .sym_valid(n_valid), .sym_data(n_data),
        .sym_ready(n_ready), .chip_en(n_en), .chip_out(n_chip),
        .chip_valid(n_cvalid), .chip_sos(n_sos)
    );

    cyclic_spreader #(.CHIPS(16)) uut_wide (
        .clk(clk), .rst_n(rst_n), .sym_valid(w_valid), .sym_data(w_data),
        .sym_ready(w_ready), .chip_en(w_en), .chip_out(w_chip),
        .chip_valid(w_cvalid), .chip_sos(w_sos)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected frame from the requirement text: build, invert, rotate one step at a time.
    function automatic logic [16:0] model(input int n, input logic [3:0] v);
        logic [15:0] root = (n == 16) ? 16'h2F53 : 16'h005C;
        logic s[16];
        logic [16:0] f = '0;
        for (int i = 0; i < n; i++) s[i] = root[n-1-i] ^ (v[3] & (i % 2 == 1));
        for (int r = 0; r < int'(v[2:0]); r++) begin
            logic t = s[n-1];
            for (int i = n - 1; i > 0; i--) s[i] = s[i-1];
            s[0] = t;
        end
        f[0] = s[n-1];
        for (int i = 0; i < n; i++) f[i+1] = s[i];
        return f;
    endfunction

    // Send one symbol and collect its frame. Called at a falling edge; returns at one.
    task automatic run_sym(input bit wide, input logic [3:0] v, input int stall_at,
                           input bit poke, output logic [16:0] got);
        int n = wide ? 16 : 8;
        got = '0;
        chk((wide ? w_ready : n_ready) == 1'b1, "R9 ready before symbol", 0, 1);
        if (wide) begin w_valid = 1'b1; w_data = v; end
        else      begin n_valid = 1'b1; n_data = v; end
        @(posedge clk); #1;
        if (wide) w_valid = 1'b0; else n_valid = 1'b0;
        for (int k = 0; k <= n; k++) begin
            logic c;
            @(negedge clk);
            c = wide ? w_chip : n_chip;
            chk((wide ? w_cvalid : n_cvalid) == 1'b1, "R3 chip_valid in frame", 0, 1);
            chk((wide ? w_sos : n_sos) == (k == 0), "R2 sos on first chip only",
                int'(wide ? w_sos : n_sos), int'(k == 0));
            chk((wide ? w_ready : n_ready) == 1'b0, "R8 ready low in frame", 1, 0);
            if (k == stall_at) begin
                if (wide) w_en = 1'b0; else n_en = 1'b0;
                @(negedge clk);
                chk((wide ? w_chip : n_chip) == c, "R7 chip held on stall",
                    int'(wide ? w_chip : n_chip), int'(c));
                chk((wide ? w_cvalid : n_cvalid) == 1'b1, "R7 valid held on stall", 0, 1);
            end
            got[k] = c;
            if (poke) begin
                if (wide) begin w_valid = 1'b1; w_data = ~v; end
                else      begin n_valid = 1'b1; n_data = ~v; end
            end
            if (wide) w_en = 1'b1; else n_en = 1'b1;
        end
        @(negedge clk);
        if (wide) begin w_en = 1'b0; w_valid = 1'b0; end
        else      begin n_en = 1'b0; n_valid = 1'b0; end
        chk((wide ? w_ready : n_ready) == 1'b1, "R9 ready after last chip", 0, 1);
        chk((wide ? w_cvalid : n_cvalid) == 1'b0, "R3 frame length", 1, 0);
    endtask

    task automatic check_literal(input logic [16:0] got, input logic [7:0] lit, input string req);
        logic [8:0] exp;
        exp[0] = lit[0];
        for (int k = 0; k < 8; k++) exp[k+1] = lit[7-k];
        chk(got[8:0] == exp, req, int'(got[8:0]), int'(exp));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(n_ready == 1'b1 && w_ready == 1'b1, "R1 ready in reset", int'(n_ready), 1);
        chk(n_cvalid == 1'b0 && n_sos == 1'b0, "R1 no chip in reset", int'(n_cvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(n_ready == 1'b1 && n_cvalid == 1'b0 && w_cvalid == 1'b0,
            "R1 idle after reset", int'(n_cvalid), 0);
    endtask

    task automatic t_literals();
        logic [16:0] g;
        run_sym(1'b0, 4'd0, -1, 1'b0, g); check_literal(g, 8'b01011100, "R4 value 0 root");
        run_sym(1'b0, 4'd1, -1, 1'b0, g); check_literal(g, 8'b00101110, "R5 value 1");
        run_sym(1'b0, 4'd2, -1, 1'b0, g); check_literal(g, 8'b00010111, "R5 value 2");
        run_sym(1'b0, 4'd8, -1, 1'b0, g); check_literal(g, 8'b00001001, "R6 value 8");
        run_sym(1'b0, 4'd9, -1, 1'b0, g); check_literal(g, 8'b10000100, "R6 value 9");
    endtask

    task automatic t_all_values();
        logic [16:0] g;
        for (int v = 0; v < 16; v++) begin
            run_sym(1'b0, 4'(v), -1, 1'b0, g);
            chk(g[8:0] == model(8, 4'(v)) [8:0], v < 8 ? "R5 rotation" : "R6 inverted rotation",
                int'(g[8:0]), int'(model(8, 4'(v)) [8:0]));
        end
    endtask

    task automatic t_stall();
        logic [16:0] g;
        run_sym(1'b0, 4'd13, 0, 1'b0, g);
        chk(g[8:0] == model(8, 4'd13) [8:0], "R7 frame with prefix stall", int'(g[8:0]), 0);
        run_sym(1'b0, 4'd6, 5, 1'b0, g);
        chk(g[8:0] == model(8, 4'd6) [8:0], "R7 frame with mid stall", int'(g[8:0]), 0);
    endtask

    task automatic t_ignore_busy();
        logic [16:0] g;
        run_sym(1'b0, 4'd3, -1, 1'b1, g);
        chk(g[8:0] == model(8, 4'd3) [8:0], "R8 poked frame unchanged", int'(g[8:0]), 0);
        run_sym(1'b0, 4'd10, -1, 1'b0, g);
        chk(g[8:0] == model(8, 4'd10) [8:0], "R8 next symbol unaffected", int'(g[8:0]), 0);
    endtask

    task automatic t_wide();
        logic [16:0] g;
        logic [3:0] vals[4] = '{4'd0, 4'd5, 4'd8, 4'd15};
        foreach (vals[i]) begin
            run_sym(1'b1, vals[i], (i == 1) ? 7 : -1, 1'b0, g);
            chk(g == model(16, vals[i]), "R10 wide frame", int'(g), int'(model(16, vals[i])));
        end
    endtask

    initial begin
        t_reset();
        t_literals();
        t_all_values();
        t_stall();
        t_ignore_busy();
        t_wide();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule